// File: doc/BRIEF.md
# Channel Event Counter with Acknowledge-Based Interrupt

This block keeps a per-channel tally of events reported by a descriptor sequencer and turns the gap between that tally and a software-maintained acknowledge count into an interrupt. Every event pulse advances a 6-bit hardware count. The first event after a list starts signals that the list was loaded, and each later event signals one finished command; the block counts both kinds the same way. Software reads one 32-bit status word. To acknowledge, it writes back the hardware count it saw into a separate acknowledge field. Both counts wrap at 64, so the number of outstanding events is always their difference modulo 64.

The interrupt output works in one of two modes. In level mode it stays high for as long as the two counts differ. An event that arrives during an acknowledge write therefore keeps the line asserted, and the event is not lost. In pulse mode the output gives one cycle per event. Two configuration inputs must both be set to enable the output. The counting itself never stops.

The status word is reached through a plain select/write/address/data port. Reads have no side effects.

Top module: `evt_ack_counter`

## Requirements
- R1: While reset is held, and in the first cycle after it, the hardware count and the acknowledge count are 0 and the interrupt output is low.
- R2: Each cycle with `evt_pulse` high increments the hardware count, read at status bits [5:0], by one in the following cycle. Cycles without a pulse leave it unchanged.
- R3: A write to the status offset (0x018) loads the acknowledge count, read at bits [21:16], from write-data bits [21:16] in the next cycle. The write never changes the hardware count.
- R4: In level mode (`cfg_level_mode`=1), `irq` is high exactly when `cfg_irq_en` and `cfg_list_irq_en` are both 1 and the two counts differ.
- R5: In pulse mode (`cfg_level_mode`=0) with the output enabled, `irq` is high for one cycle, namely the cycle after each event pulse, and is low otherwise.
- R6: Status bit 8 reads the current value of `irq`.
- R7: An event in the same cycle as an acknowledge write both increments the hardware count and loads the written value. In level mode with the output enabled, `irq` then stays high.
- R8: Both counts wrap from 63 to 0.
- R9: Writes to any address other than 0x018 have no effect, and reads from such addresses return 0.
- R10: Events are counted while the interrupt output is disabled.
- R11: All status bits other than [5:0], 8 and [21:16] read as 0, whatever value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 1 | One-cycle event from the descriptor sequencer |
| cfg_irq_en | input | 1 | Interrupt enable from the channel configuration |
| cfg_list_irq_en | input | 1 | List interrupt enable from the channel configuration |
| cfg_level_mode | input | 1 | 1 = level output, 0 = one pulse per event |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Channel-relative byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, 0 when not reading the status offset |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions assume that `evt_pulse` is a clean one-cycle-or-longer signal and that the configuration inputs change only between cycles. They also assume that a write is a single-cycle strobe with valid address and data. The bench drives every input from tasks at the falling edge. It holds a status read at all other times, so the outputs can be compared on each cycle against a behavioural model. It also changes mode bits only between transactions, so no property sees a half-applied configuration.

// File: rtl/evt_ack_pkg.sv
package evt_ack_pkg;

    localparam int CNT_W      = 6;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int DONE_LSB   = 0;
    localparam int ACTIVE_BIT = 8;
    localparam int ACK_LSB    = 16;
    localparam logic [ADDR_W-1:0] STATUS_OFFSET = 12'h018;

    typedef struct packed {
        logic level;
        logic list_en;
        logic irq_en;
    } irq_cfg_t;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic [CNT_W-1:0] done_cnt,
        input logic [CNT_W-1:0] ack_cnt,
        input logic             active
    );
        logic [DATA_W-1:0] w;
        w = '0;
        w[DONE_LSB +: CNT_W] = done_cnt;
        w[ACK_LSB  +: CNT_W] = ack_cnt;
        w[ACTIVE_BIT]        = active;
        return w;
    endfunction

endpackage

// File: rtl/evt_done_counter.sv
module evt_done_counter #(
    parameter int CNT_W = evt_ack_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    output logic [CNT_W-1:0] done_o
);
    logic [CNT_W-1:0] done_q;

    always_ff @(posedge clk) begin
        if (rst) done_q <= '0;
        else if (evt_i) done_q <= done_q + CNT_W'(1);
    end

    assign done_o = done_q;

    assert_done_step_R2: assert property (@(posedge clk) disable iff (rst)
        evt_i |=> done_q == $past(done_q) + CNT_W'(1));
    assert_done_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !evt_i |=> $stable(done_q));
    assert_done_reset_R1: assert property (@(posedge clk)
        rst |=> done_q == '0);
endmodule

// File: rtl/evt_ack_register.sv
module evt_ack_register #(
    parameter int CNT_W = evt_ack_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    output logic [CNT_W-1:0] ack_o
);
    logic [CNT_W-1:0] ack_q;

    always_ff @(posedge clk) begin
        if (rst) ack_q <= '0;
        else if (load_i) ack_q <= value_i;
    end

    assign ack_o = ack_q;

    assert_ack_load_R3: assert property (@(posedge clk) disable iff (rst)
        load_i |=> ack_q == $past(value_i));
    assert_ack_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(ack_q));
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
    parameter int CNT_W = evt_ack_pkg::CNT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  evt_ack_pkg::irq_cfg_t cfg_i,
    input  logic                  evt_i,
    input  logic [CNT_W-1:0]      done_i,
    input  logic [CNT_W-1:0]      ack_i,
    output logic                  irq_o
);
    logic pulse_q;
    logic enabled;
    logic pending;

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= evt_i;
    end

    assign enabled = cfg_i.irq_en & cfg_i.list_en;
    assign pending = (done_i != ack_i);
    assign irq_o   = enabled & (cfg_i.level ? pending : pulse_q);

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_i.level && !evt_i) |=> (cfg_i.level || !irq_o));
    assert_irq_reset_R1: assert property (@(posedge clk)
        rst |=> !irq_o);
endmodule

// File: rtl/evt_ack_counter.sv
module evt_ack_counter #(
    parameter int CNT_W  = evt_ack_pkg::CNT_W,
    parameter int DATA_W = evt_ack_pkg::DATA_W,
    parameter int ADDR_W = evt_ack_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_pulse,
    input  logic              cfg_irq_en,
    input  logic              cfg_list_irq_en,
    input  logic              cfg_level_mode,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    import evt_ack_pkg::*;

    localparam int ACK_MSB = ACK_LSB + CNT_W - 1;

    irq_cfg_t         cfg;
    logic             hit;
    logic             ack_wr;
    logic [CNT_W-1:0] done_cnt;
    logic [CNT_W-1:0] ack_cnt;
    logic             irq_int;
    logic             unused_wbits;

    assign cfg    = '{level: cfg_level_mode, list_en: cfg_list_irq_en, irq_en: cfg_irq_en};
    assign hit    = reg_sel && (reg_addr == STATUS_OFFSET);
    assign ack_wr = hit && reg_wr;
    assign unused_wbits = ^{reg_wdata[DATA_W-1:ACK_MSB+1], reg_wdata[ACK_LSB-1:0]};

    evt_done_counter #(.CNT_W(CNT_W)) u_done (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_pulse),
        .done_o (done_cnt)
    );

    evt_ack_register #(.CNT_W(CNT_W)) u_ack (
        .clk     (clk),
        .rst     (rst),
        .load_i  (ack_wr),
        .value_i (reg_wdata[ACK_MSB:ACK_LSB]),
        .ack_o   (ack_cnt)
    );

    evt_irq_gen #(.CNT_W(CNT_W)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .cfg_i  (cfg),
        .evt_i  (evt_pulse),
        .done_i (done_cnt),
        .ack_i  (ack_cnt),
        .irq_o  (irq_int)
    );

    assign irq       = irq_int;
    assign reg_rdata = (hit && !reg_wr) ? pack_status(done_cnt, ack_cnt, irq_int) : '0;

    assert_ack_race_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && evt_pulse && cfg_level_mode && cfg_irq_en && cfg_list_irq_en
         && reg_wdata[ACK_MSB:ACK_LSB] == done_cnt)
        |=> (irq || !(cfg_level_mode && cfg_irq_en && cfg_list_irq_en)));
endmodule

// File: tb/evt_ack_counter_tb.sv
module evt_ack_counter_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_pulse = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        cfg_list_irq_en = 1'b0;
    logic        cfg_level_mode = 1'b1;
    logic        reg_sel = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = 12'h018;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int done_m = 0;
    int ack_m  = 0;
    bit pulse_m = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    evt_ack_counter u_dut (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse),
        .cfg_irq_en(cfg_irq_en), .cfg_list_irq_en(cfg_list_irq_en),
        .cfg_level_mode(cfg_level_mode), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic bit exp_irq();
        bit en = cfg_irq_en && cfg_list_irq_en;
        if (cfg_level_mode) return en && (done_m != ack_m);
        return en && pulse_m;
    endfunction

    task automatic compare(input string tag);
        logic [31:0] exp_word;
        bit          ei = exp_irq();
        exp_word = '0;
        exp_word[5:0]   = 6'(done_m);
        exp_word[21:16] = 6'(ack_m);
        exp_word[8]     = ei;
        checks++;
        if (reg_rdata !== exp_word || irq !== ei) begin
            errors++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     tag, reg_rdata, irq, exp_word, ei);
        end
    endtask

    task automatic step(input bit ev, input bit wr, input logic [11:0] addr,
                        input logic [31:0] wd, input string tag);
        evt_pulse = ev; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        @(posedge clk);
        #1;
        if (rst) begin
            done_m = 0; ack_m = 0; pulse_m = 0;
        end else begin
            if (ev) done_m = (done_m + 1) % 64;
            if (wr && addr == 12'h018) ack_m = int'(wd[21:16]);
            pulse_m = ev;
        end
        evt_pulse = 1'b0; reg_wr = 1'b0; reg_addr = 12'h018; reg_wdata = '0;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 12'h018, '0, tag);
    endtask

    task automatic ack_seen(input string tag);
        step(0, 1, 12'h018, {10'h3ff, 6'(done_m), 16'hffff}, tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 50000", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        idle(3, "R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        idle(1, "R1 after reset");

        // R10, R2: counting while output disabled
        for (int i = 0; i < 3; i++) step(1, 0, 12'h018, '0, "R10 count disabled");
        idle(1, "R2 hold without pulse");

        // R4, R6: level mode enabled, pending events
        cfg_irq_en = 1'b1;
        idle(1, "R4 list enable off");
        cfg_list_irq_en = 1'b1;
        idle(1, "R4 R6 level pending");

        // R3, R11: acknowledge with garbage in other bits
        ack_seen("R3 R11 ack clears level");
        step(0, 1, 12'h018, 32'hffc0_ffff, "R3 done read-only");
        ack_seen("R3 re-ack");

        // R9: other addresses
        step(0, 1, 12'h01c, 32'h0015_0000, "R9 write other addr ignored");
        @(negedge clk);
        reg_addr = 12'h01c; #1;
        checks++;
        if (reg_rdata !== 32'h0) begin
            errors++;
            $display("FAIL R9: rdata=%h expected 00000000", reg_rdata);
        end
        reg_addr = 12'h018;
        idle(1, "R9 state unchanged");

        // R8: wrap past 63
        for (int i = 0; i < 70; i++) step(1, 0, 12'h018, '0, "R8 wrap count");
        ack_seen("R8 ack after wrap");
        step(0, 1, 12'h018, 32'h003f_0000, "R8 ack at 63");
        ack_seen("R8 ack restore");

        // R7: event during acknowledge
        step(1, 0, 12'h018, '0, "R7 setup");
        step(1, 1, 12'h018, {10'h0, 6'(done_m), 16'h0}, "R7 race keeps irq");
        idle(1, "R7 still pending");
        ack_seen("R7 final ack");

        // R5: pulse mode
        cfg_level_mode = 1'b0;
        idle(1, "R5 pulse idle");
        step(1, 0, 12'h018, '0, "R5 single pulse");
        idle(2, "R5 pulse drops");
        for (int i = 0; i < 3; i++) step(1, 0, 12'h018, '0, "R5 back to back");
        idle(1, "R5 after burst");
        cfg_irq_en = 1'b0;
        step(1, 0, 12'h018, '0, "R5 disabled pulse");
        cfg_irq_en = 1'b1;
        cfg_level_mode = 1'b1;
        idle(1, "R4 back to level");
        ack_seen("R4 ack in level");

        // R1: reset mid-run
        step(1, 0, 12'h018, '0, "R1 pre-reset");
        rst = 1'b1;
        idle(1, "R1 reset again");
        rst = 1'b0;
        idle(2, "R1 released");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule